// File: doc/BRIEF.md
# Serial FIFO Trigger and Flow Control

This block sits between a host register port and a serial shift-register core. It buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO. From the fill levels of the two queues it produces two level flags:

- A receive-threshold flag tells the host that enough bytes are waiting to be read.
- A transmit-low flag tells the host that the outgoing queue has drained to a chosen number of remaining bytes.

Both thresholds come from 2-bit selects in a small control register. The receive mapping also depends on whether the link runs asynchronously or synchronously.

The same control register holds a flow-control enable. When it is set, the incoming clear-to-send line (active low) can stall hand-over of new bytes to the transmitter. The outgoing request-to-send line (active low) goes high while the receive queue is at or above its threshold. When the enable is clear, the clear-to-send line is ignored and request-to-send stays low. Synchronous mode always overrides the enable to off. Host misuse is ignored and recorded in two sticky error bits, which the host clears by writing 1:

- a write to a full transmit queue;
- a read from an empty receive queue.

Top module: `sfifo_flowctl`

## Requirements
- R1: After reset both queues are empty (levels 0) and all control fields are 0. Both error bits are 0, `rts_n_pin` is 0, `rdf_flag` is 0, `tdfe_flag` is 1 and `core_tx_valid` is 0.
- R2: The transmit queue holds up to 16 bytes and hands them to the core in write order. `core_tx_valid` is high only when the queue is non-empty and not held by flow control. A byte leaves in a cycle where both `core_tx_valid` and `core_tx_ready` are high.
- R3: The receive queue holds up to 16 bytes. `rx_data` shows the oldest byte and `rx_pop` removes it. A byte offered by the core while the queue is full is dropped.
- R4: With `mode_sync`=0, `rdf_flag` is 1 exactly when `rx_level` is at least the threshold set by `cfg_rx_sel`: 0→1, 1→4, 2→8, 3→14.
- R5: With `mode_sync`=1, the `cfg_rx_sel` thresholds are 0→1, 1→2, 2→8, 3→14.
- R6: `tdfe_flag` is 1 exactly when `tx_level` is at most the threshold set by `cfg_tx_sel`: 0→8, 1→4, 2→2, 3→0.
- R7: When the stored enable `cfg_mce` is 0, `rts_n_pin` is 0 and `cts_n_pin` has no effect on `core_tx_valid`.
- R8: When flow control is in effect, `rts_n_pin` equals 1 while `rx_level` is at or above the receive threshold and 0 below it.
- R9: When flow control is in effect and `cts_n_pin` is 1, `core_tx_valid` is 0 and no byte leaves the transmit queue.
- R10: With `mode_sync`=1, flow control is off even when the stored `cfg_mce` is 1.
- R11: A `tx_push` while `tx_level` is 16 stores nothing and sets the sticky `err_tx_ovf`.
- R12: An `rx_pop` while `rx_level` is 0 changes nothing in the queue and sets the sticky `err_rx_udf`.
- R13: `err_clr[0]`=1 clears `err_tx_ovf` and `err_clr[1]`=1 clears `err_rx_udf`. A new error event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sync | input | 1 | 1 = synchronous link, 0 = asynchronous |
| cfg_we | input | 1 | Load the control register from the cfg_* fields |
| cfg_rx_sel | input | 2 | Receive threshold select |
| cfg_tx_sel | input | 2 | Transmit remaining-count select |
| cfg_mce | input | 1 | Flow-control enable |
| tx_push | input | 1 | Host write into the transmit queue |
| tx_data | input | 8 | Byte written by the host |
| rx_pop | input | 1 | Host read from the receive queue |
| rx_data | output | 8 | Oldest received byte |
| err_clr | input | 2 | Write-1 clear: bit 0 overflow, bit 1 underflow |
| err_tx_ovf | output | 1 | Sticky transmit overflow |
| err_rx_udf | output | 1 | Sticky receive underflow |
| rdf_flag | output | 1 | Receive level reached threshold |
| tdfe_flag | output | 1 | Transmit remaining count at or below threshold |
| tx_level | output | 5 | Bytes in the transmit queue |
| rx_level | output | 5 | Bytes in the receive queue |
| core_tx_valid | output | 1 | Byte offered to the transmitter |
| core_tx_data | output | 8 | Byte offered to the transmitter |
| core_tx_ready | input | 1 | Transmitter takes the offered byte |
| core_rx_valid | input | 1 | Receiver delivers a byte |
| core_rx_data | input | 8 | Delivered byte |
| cts_n_pin | input | 1 | Clear-to-send, active low |
| rts_n_pin | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with its defaults: a depth of 16 and 8-bit data. At that depth every threshold code is reachable, including the top receive threshold of 14 and the transmit threshold of zero remaining. The bench sweeps both queues through every fill level from 0 to 16 and checks all four select codes at each level, in both link modes. Filling to 16 also brings the overflow and dropped-byte boundaries into reach, and draining to 0 brings the underflow boundary into reach.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       mce;
  } sfifo_cfg_t;

  // Receive threshold in bytes; code 1 differs between link modes.
  function automatic int unsigned rx_trig_level(logic [1:0] sel, logic sync);
    case (sel)
      2'd0:    return 1;
      2'd1:    return sync ? 2 : 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Transmit threshold as bytes still queued: halves per code, last code is zero.
  function automatic int unsigned tx_trig_level(logic [1:0] sel);
    if (sel == 2'd3) return 0;
    return 8 >> sel;
  endfunction

endpackage

// File: rtl/sfifo_buf.sv
module sfifo_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_ctl.sv
module sfifo_ctl
  import sfifo_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sync,
  input  logic             cfg_we,
  input  sfifo_cfg_t       cfg_in,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             cts_n_pin,
  input  logic             ovf_evt,
  input  logic             udf_evt,
  input  logic [1:0]       err_clr,
  output logic             rdf,
  output logic             tdfe,
  output logic             rts_n,
  output logic             tx_gate,
  output logic             mce_eff,
  output logic             err_ovf,
  output logic             err_udf
);
  sfifo_cfg_t       cfg_q;
  logic [CNT_W-1:0] rx_trig, tx_trig;
  logic             rx_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_in;
  end

  assign mce_eff = cfg_q.mce & ~mode_sync;
  assign rx_trig = CNT_W'(rx_trig_level(cfg_q.rx_sel, mode_sync));
  assign tx_trig = CNT_W'(tx_trig_level(cfg_q.tx_sel));
  assign rx_hit  = (rx_level >= rx_trig);
  assign rdf     = rx_hit;
  assign tdfe    = (tx_level <= tx_trig);
  assign rts_n   = mce_eff & rx_hit;
  assign tx_gate = ~(mce_eff & cts_n_pin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_ovf <= 1'b0;
      err_udf <= 1'b0;
    end else begin
      err_ovf <= ovf_evt | (err_ovf & ~err_clr[0]);
      err_udf <= udf_evt | (err_udf & ~err_clr[1]);
    end
  end
endmodule

// File: rtl/sfifo_flowctl.sv
module sfifo_flowctl
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_rx_sel,
  input  logic [1:0]        cfg_tx_sel,
  input  logic              cfg_mce,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  input  logic [1:0]        err_clr,
  output logic              err_tx_ovf,
  output logic              err_rx_udf,
  output logic              rdf_flag,
  output logic              tdfe_flag,
  output logic [CNT_W-1:0]  tx_level,
  output logic [CNT_W-1:0]  rx_level,
  output logic              core_tx_valid,
  output logic [DATA_W-1:0] core_tx_data,
  input  logic              core_tx_ready,
  input  logic              core_rx_valid,
  input  logic [DATA_W-1:0] core_rx_data,
  input  logic              cts_n_pin,
  output logic              rts_n_pin
);
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic       tx_gate, mce_eff;
  logic       tx_push_rej, rx_pop_rej, tx_handoff;
  sfifo_cfg_t cfg_in;

  assign cfg_in        = '{rx_sel: cfg_rx_sel, tx_sel: cfg_tx_sel, mce: cfg_mce};
  assign tx_push_rej   = tx_push & tx_full;
  assign rx_pop_rej    = rx_pop & rx_empty;
  assign core_tx_valid = ~tx_empty & tx_gate;
  assign tx_handoff    = core_tx_valid & core_tx_ready;

  sfifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(tx_data), .pop(tx_handoff),
    .head(core_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sfifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(core_rx_valid), .push_data(core_rx_data), .pop(rx_pop),
    .head(rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sfifo_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync),
    .cfg_we(cfg_we), .cfg_in(cfg_in),
    .rx_level(rx_level), .tx_level(tx_level), .cts_n_pin(cts_n_pin),
    .ovf_evt(tx_push_rej), .udf_evt(rx_pop_rej), .err_clr(err_clr),
    .rdf(rdf_flag), .tdfe(tdfe_flag), .rts_n(rts_n_pin),
    .tx_gate(tx_gate), .mce_eff(mce_eff),
    .err_ovf(err_tx_ovf), .err_udf(err_rx_udf)
  );

  logic unused_rx_full;
  assign unused_rx_full = rx_full;
endmodule

// File: rtl/sfifo_flowctl_chk.sv
module sfifo_flowctl_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_sync,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             core_tx_valid,
  input logic             core_tx_ready,
  input logic             core_rx_valid,
  input logic             cts_n_pin,
  input logic             rts_n_pin,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic             err_tx_ovf,
  input logic             err_rx_udf,
  input logic [1:0]       err_clr,
  input logic             rdf_flag,
  input logic             tdfe_flag,
  input logic             mce_eff,
  input logic             tx_push_rej,
  input logic             rx_pop_rej
);
  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_rej |=> err_tx_ovf); // R11
  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_level == CNT_W'(DEPTH) && !(core_tx_valid && core_tx_ready)
    |=> tx_level == CNT_W'(DEPTH)); // R11
  AST_RX_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_rej |=> err_rx_udf); // R12
  AST_RX_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_level == '0 && !core_rx_valid |=> rx_level == '0); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_tx_ovf && !err_clr[0] |=> err_tx_ovf); // R13
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_rx_udf && !err_clr[1] |=> err_rx_udf); // R13
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mce_eff && cts_n_pin |-> !core_tx_valid); // R9
  AST_SYNC_NO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync |-> !rts_n_pin); // R10
  AST_MODEM_OFF_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    !mce_eff |-> !rts_n_pin); // R7
  AST_RTS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    mce_eff |-> rts_n_pin == rdf_flag); // R8
  AST_TDFE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level == '0 |-> tdfe_flag); // R6
  AST_RDF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == '0 |-> !rdf_flag); // R4
  AST_NO_EMPTY_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_valid |-> tx_level != '0); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CNT_W'(DEPTH) && rx_level <= CNT_W'(DEPTH)); // R3
endmodule

bind sfifo_flowctl sfifo_flowctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync),
  .tx_push(tx_push), .rx_pop(rx_pop),
  .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
  .core_rx_valid(core_rx_valid), .cts_n_pin(cts_n_pin), .rts_n_pin(rts_n_pin),
  .tx_level(tx_level), .rx_level(rx_level),
  .err_tx_ovf(err_tx_ovf), .err_rx_udf(err_rx_udf), .err_clr(err_clr),
  .rdf_flag(rdf_flag), .tdfe_flag(tdfe_flag), .mce_eff(mce_eff),
  .tx_push_rej(tx_push_rej), .rx_pop_rej(rx_pop_rej)
);

// File: tb/sim_sfifo_flowctl.sv
module sim_sfifo_flowctl;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mode_sync, cfg_we, cfg_mce, tx_push, rx_pop;
  logic core_tx_ready, core_rx_valid, cts_n_pin;
  logic [1:0] cfg_rx_sel, cfg_tx_sel, err_clr;
  logic [DW-1:0] tx_data, core_rx_data, rx_data, core_tx_data;
  logic err_tx_ovf, err_rx_udf, rdf_flag, tdfe_flag, core_tx_valid, rts_n_pin;
  logic [CW-1:0] tx_level, rx_level;

  sfifo_flowctl #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .cfg_we(cfg_we),
    .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel), .cfg_mce(cfg_mce),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
    .err_clr(err_clr), .err_tx_ovf(err_tx_ovf), .err_rx_udf(err_rx_udf),
    .rdf_flag(rdf_flag), .tdfe_flag(tdfe_flag),
    .tx_level(tx_level), .rx_level(rx_level),
    .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
    .core_tx_ready(core_tx_ready), .core_rx_valid(core_rx_valid),
    .core_rx_data(core_rx_data), .cts_n_pin(cts_n_pin), .rts_n_pin(rts_n_pin)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  int rx_async_t[4] = '{1, 4, 8, 14};
  int rx_sync_t[4]  = '{1, 2, 8, 14};
  int tx_t[4]       = '{8, 4, 2, 0};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic cfg(int r, int t, bit m);
    cfg_rx_sel = 2'(r); cfg_tx_sel = 2'(t); cfg_mce = m; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic host_push(logic [DW-1:0] b);
    if (txq.size() < DEPTH) txq.push_back(b);
    tx_push = 1'b1; tx_data = b;
    step();
    tx_push = 1'b0;
  endtask

  task automatic core_send(logic [DW-1:0] b);
    if (rxq.size() < DEPTH) rxq.push_back(b);
    core_rx_valid = 1'b1; core_rx_data = b;
    step();
    core_rx_valid = 1'b0;
  endtask

  task automatic host_pop_check(string req);
    @(negedge clk);
    if (rxq.size() > 0) check(req, rx_data, rxq.pop_front());
    rx_pop = 1'b1;
    step();
    rx_pop = 1'b0;
  endtask

  task automatic tx_drain_one();
    core_tx_ready = 1'b1;
    step();
    core_tx_ready = 1'b0;
  endtask

  task automatic rx_sweep(bit sync);
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int s = 0; s < 4; s++) begin
        cfg(s, 0, 1'b1);
        @(negedge clk);
        if (sync) begin
          check("R5 rdf sync threshold", rdf_flag, int'(lvl >= rx_sync_t[s]));
          check("R10 rts low in sync mode", rts_n_pin, 0);
        end else begin
          check("R4 rdf async threshold", rdf_flag, int'(lvl >= rx_async_t[s]));
          check("R8 rts follows rx threshold", rts_n_pin, int'(lvl >= rx_async_t[s]));
        end
      end
      if (lvl < DEPTH) core_send(DW'(8'h80 + lvl + (sync ? 32 : 0)));
    end
  endtask

  // Scoreboard monitor: each hand-over must match the oldest queued byte.
  always @(negedge clk) begin
    if (rst_n && core_tx_valid && core_tx_ready) begin
      if (txq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected handoff actual=%0d expected=none", core_tx_data);
      end else begin
        check("R2 tx order", core_tx_data, txq.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sync = 1'b0; cfg_we = 1'b0; cfg_mce = 1'b0;
    cfg_rx_sel = '0; cfg_tx_sel = '0; err_clr = '0;
    tx_push = 1'b0; tx_data = '0; rx_pop = 1'b0;
    core_tx_ready = 1'b0; core_rx_valid = 1'b0; core_rx_data = '0; cts_n_pin = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    @(negedge clk);
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 rdf", rdf_flag, 0);
    check("R1 tdfe", tdfe_flag, 1);
    check("R1 rts", rts_n_pin, 0);
    check("R1 err_tx_ovf", err_tx_ovf, 0);
    check("R1 err_rx_udf", err_rx_udf, 0);
    check("R1 core_tx_valid", core_tx_valid, 0);

    for (int n = 1; n <= DEPTH; n++) begin
      host_push(DW'(8'h30 + n));
      @(negedge clk);
      check("R6 tdfe code0 while filling", tdfe_flag, int'(n <= 8));
      check("R2 tx_level", tx_level, n);
    end

    host_push(8'hEE);
    @(negedge clk);
    check("R11 overflow flagged", err_tx_ovf, 1);
    check("R11 level unchanged", tx_level, DEPTH);
    step();
    @(negedge clk);
    check("R11 overflow sticky", err_tx_ovf, 1);

    err_clr = 2'b01;
    step();
    err_clr = 2'b00;
    @(negedge clk);
    check("R13 overflow cleared", err_tx_ovf, 0);

    for (int lvl = DEPTH; lvl >= 0; lvl--) begin
      for (int s = 0; s < 4; s++) begin
        cfg(0, s, 1'b0);
        @(negedge clk);
        check("R6 tdfe threshold", tdfe_flag, int'(lvl <= tx_t[s]));
      end
      if (lvl > 0) tx_drain_one();
    end
    check("R2 all bytes handed over", txq.size(), 0);

    rx_pop = 1'b1;
    step();
    rx_pop = 1'b0;
    @(negedge clk);
    check("R12 underflow flagged", err_rx_udf, 1);
    check("R12 level unchanged", rx_level, 0);
    rx_pop = 1'b1; err_clr = 2'b10;
    step();
    rx_pop = 1'b0; err_clr = 2'b00;
    @(negedge clk);
    check("R13 new event wins over clear", err_rx_udf, 1);
    err_clr = 2'b10;
    step();
    err_clr = 2'b00;
    @(negedge clk);
    check("R13 underflow cleared", err_rx_udf, 0);

    mode_sync = 1'b0;
    rx_sweep(1'b0);
    core_send(8'hFF);
    @(negedge clk);
    check("R3 byte dropped when full", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) host_pop_check("R3 rx order");
    @(negedge clk);
    check("R3 rx drained", rx_level, 0);
    check("R8 rts low below threshold", rts_n_pin, 0);

    mode_sync = 1'b1;
    rx_sweep(1'b1);
    mode_sync = 1'b0;
    cfg(0, 0, 1'b0);
    @(negedge clk);
    check("R7 rdf set with full queue", rdf_flag, 1);
    check("R7 rts low when disabled", rts_n_pin, 0);
    for (int i = 0; i < DEPTH; i++) host_pop_check("R3 rx order sync fill");

    cts_n_pin = 1'b1;
    host_push(8'hA1);
    host_push(8'hA2);
    @(negedge clk);
    check("R7 cts ignored when disabled", core_tx_valid, 1);
    tx_drain_one();
    tx_drain_one();
    @(negedge clk);
    check("R7 bytes left despite cts", tx_level, 0);

    cfg(0, 0, 1'b1);
    host_push(8'hB1);
    host_push(8'hB2);
    core_tx_ready = 1'b1;
    repeat (3) step();
    @(negedge clk);
    check("R9 valid held by cts", core_tx_valid, 0);
    check("R9 no byte leaves", tx_level, 2);
    cts_n_pin = 1'b0;
    step();
    step();
    core_tx_ready = 1'b0;
    @(negedge clk);
    check("R9 drains after cts low", tx_level, 0);

    mode_sync = 1'b1;
    cts_n_pin = 1'b1;
    host_push(8'hC1);
    @(negedge clk);
    check("R10 sync overrides flow control", core_tx_valid, 1);
    tx_drain_one();
    @(negedge clk);
    check("R10 byte left in sync mode", tx_level, 0);
    check("R2 scoreboard empty", txq.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule